// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block stretches bus cycles so that slow memories and peripherals have time to answer. It watches the memory-request and I/O-request strobes, classifies each new bus cycle when it begins, and loads a small down-counter with the number of wait states that cycle should receive. While the counter is non-zero, or while an external device holds its wait line, the combined ready output stays low and the bus sequencer holds the cycle open.

A control register holds one wait count for memory cycles and another for I/O cycles. The CPU sequencer and the on-chip DMA sequencer drive the same strobes, so both see the same settings. Chip-select wait generators (RAM, ROM and similar) can also ask for waits on memory cycles. The block does not add those requests together. It inserts the largest count among the programmed memory count and every selected chip-select count. Refresh cycles, and strobe states that are neither memory nor I/O, receive no programmed waits.

Top module: `bus_wait_gen`

## Requirements
- R1: After reset, both wait fields of the control register hold 3, the counter is zero, and `bus_ready` is high while `ext_wait` is low.
- R2: A cycle with `cfg_we` high writes the control register: the memory wait count from `cfg_wdata[1:0]` and the I/O wait count from `cfg_wdata[3:2]`. The new values apply to every cycle that starts afterwards.
- R3: A bus cycle starts on the first clock edge where `mem_req` or `io_req` is high after an edge where both were low. Strobe changes while either strobe stays high do not start a new cycle and do not reload the counter.
- R4: A memory cycle (`mem_req` high, `refresh` low) with an effective count N (0 to 3) holds `bus_ready` low for exactly the N clocks that follow the start edge, then raises it.
- R5: An I/O cycle (`io_req` high, `mem_req` low) uses the I/O wait count. When both strobes are high at the start, the cycle is treated as a memory cycle.
- R6: On a memory cycle, the effective count is the largest of the programmed memory count and each `cs_wait` field (2 bits per source, source k at bits [2k+1:2k]) whose `cs_sel[k]` is high. Counts are never summed. Chip-select requests are ignored on I/O cycles.
- R7: A cycle that starts with `mem_req` and `refresh` both high receives zero waits, whatever the programmed and chip-select counts are.
- R8: `bus_ready` is low in every cycle in which `ext_wait` is high, so the external line extends a cycle beyond the programmed waits.
- R9: Once loaded, the counter decrements by exactly one per clock. It stops at zero and never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Control register data: memory count [1:0], I/O count [3:2] |
| mem_req | input | 1 | Memory request strobe, active high |
| io_req | input | 1 | I/O request strobe, active high |
| refresh | input | 1 | Marks the current memory request as a refresh cycle |
| cs_sel | input | 2 | Chip-select wait source active for this cycle (bit 0 RAM, bit 1 ROM) |
| cs_wait | input | 4 | Wait count requested by each chip-select source, 2 bits each |
| ext_wait | input | 1 | External wait request, active high |
| bus_ready | output | 1 | Combined ready to the bus sequencer; low means insert a wait state |

## Verification
Properties check on every cycle that ready is low while the counter is non-zero or the external line is high. They also check that the counter counts down by one without wrapping, that a start is never seen on two edges in a row, that refresh cycles load zero, and that memory cycles load at least the programmed memory count. Only the bench scenarios show the exact number of low-ready clocks per cycle type, the maximum-not-sum merge for different chip-select combinations, the effect of a register write on later cycles, and that strobe changes inside a cycle do not restart the wait.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

  // Bus cycle classification made at cycle start
  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_MEM  = 2'd1,
    CYC_IO   = 2'd2,
    CYC_RFSH = 2'd3
  } cyc_kind_e;

endpackage

// File: rtl/bwg_cycle_detect.sv
module bwg_cycle_detect
  import bwg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mem_req,
  input  logic      io_req,
  input  logic      refresh,
  output logic      start,
  output cyc_kind_e kind
);

  logic active;
  logic active_q;
  logic active_d;

  assign active = mem_req | io_req;

  // A cycle starts when a strobe appears after an idle edge
  assign start = active & ~active_q;

  always_comb begin
    if (mem_req && refresh)      kind = CYC_RFSH;
    else if (mem_req)            kind = CYC_MEM;
    else if (io_req)             kind = CYC_IO;
    else                         kind = CYC_NONE;
  end

  always_comb begin
    active_d = active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start); // R3

endmodule

// File: rtl/bwg_wait_select.sv
module bwg_wait_select
  import bwg_pkg::*;
#(
  parameter int CNT_W  = 2,
  parameter int NUM_CS = 2
) (
  input  cyc_kind_e                  kind,
  input  logic [CNT_W-1:0]           mem_cnt,
  input  logic [CNT_W-1:0]           io_cnt,
  input  logic [NUM_CS-1:0]          cs_sel,
  input  logic [NUM_CS*CNT_W-1:0]    cs_wait,
  output logic [CNT_W-1:0]           sel_cnt
);

  // Running maximum over the programmed memory count and selected sources
  logic [CNT_W-1:0] max_chain [NUM_CS+1];

  assign max_chain[0] = mem_cnt;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs_max
    logic [CNT_W-1:0] src;
    assign src = cs_wait[g*CNT_W +: CNT_W];
    assign max_chain[g+1] = (cs_sel[g] && (src > max_chain[g])) ? src : max_chain[g];
  end

  always_comb begin
    case (kind)
      CYC_MEM: sel_cnt = max_chain[NUM_CS];
      CYC_IO:  sel_cnt = io_cnt;
      default: sel_cnt = '0;
    endcase
  end

endmodule

// File: rtl/bwg_wait_counter.sv
module bwg_wait_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load | (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R9

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import bwg_pkg::*;
#(
  parameter int CNT_W  = 2,
  parameter int NUM_CS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [2*CNT_W-1:0]      cfg_wdata,
  input  logic                    mem_req,
  input  logic                    io_req,
  input  logic                    refresh,
  input  logic [NUM_CS-1:0]       cs_sel,
  input  logic [NUM_CS*CNT_W-1:0] cs_wait,
  input  logic                    ext_wait,
  output logic                    bus_ready
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Control register: memory count low field, I/O count high field
  logic [CNT_W-1:0] mem_wait_q, mem_wait_d;
  logic [CNT_W-1:0] io_wait_q,  io_wait_d;

  always_comb begin
    mem_wait_d = cfg_wdata[CNT_W-1:0];
    io_wait_d  = cfg_wdata[2*CNT_W-1:CNT_W];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mem_wait_q <= CNT_MAX;
      io_wait_q  <= CNT_MAX;
    end else if (cfg_we) begin
      mem_wait_q <= mem_wait_d;
      io_wait_q  <= io_wait_d;
    end
  end

  logic             cyc_start;
  cyc_kind_e        cyc_kind;
  logic [CNT_W-1:0] sel_cnt;
  logic [CNT_W-1:0] wait_cnt;

  bwg_cycle_detect u_detect (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mem_req (mem_req),
    .io_req  (io_req),
    .refresh (refresh),
    .start   (cyc_start),
    .kind    (cyc_kind)
  );

  bwg_wait_select #(
    .CNT_W  (CNT_W),
    .NUM_CS (NUM_CS)
  ) u_select (
    .kind    (cyc_kind),
    .mem_cnt (mem_wait_q),
    .io_cnt  (io_wait_q),
    .cs_sel  (cs_sel),
    .cs_wait (cs_wait),
    .sel_cnt (sel_cnt)
  );

  bwg_wait_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (cyc_start),
    .load_val (sel_cnt),
    .cnt      (wait_cnt)
  );

  // External wait extends the cycle once programmed waits run out
  assign bus_ready = (wait_cnt == '0) & ~ext_wait;

  AST_WAIT_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wait_cnt != '0) |-> !bus_ready); // R4

  AST_EXT_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ext_wait |-> !bus_ready); // R8

  AST_RFSH_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cyc_start && mem_req && refresh) |=> (wait_cnt == '0)); // R7

  AST_MEM_AT_LEAST_PROG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cyc_start && mem_req && !refresh) |=> (wait_cnt >= $past(mem_wait_q))); // R6

  AST_IO_USES_IO_FIELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cyc_start && io_req && !mem_req) |=> (wait_cnt == $past(io_wait_q))); // R5

endmodule

// File: tb/bus_wait_gen_bench.sv
module bus_wait_gen_bench;

  localparam int CLK_P = 10;

  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [3:0] cfg_wdata;
  logic       mem_req;
  logic       io_req;
  logic       refresh;
  logic [1:0] cs_sel;
  logic [3:0] cs_wait;
  logic       ext_wait;
  logic       bus_ready;

  int n_tests = 0;
  int n_fail  = 0;

  // Scoreboard: expected ready level per negative edge, with its requirement tag
  logic  exp_q[$];
  string tag_q[$];
  logic  mon_exp;
  string mon_tag;

  bus_wait_gen u_bus_wait_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .mem_req   (mem_req),
    .io_req    (io_req),
    .refresh   (refresh),
    .cs_sel    (cs_sel),
    .cs_wait   (cs_wait),
    .ext_wait  (ext_wait),
    .bus_ready (bus_ready)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic push(input logic e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // Monitor: pops one expectation per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      mon_exp = exp_q.pop_front();
      mon_tag = tag_q.pop_front();
      n_tests++;
      if (bus_ready !== mon_exp) begin
        n_fail++;
        $display("[TB] FAIL %s: bus_ready=%b expected=%b at %0t", mon_tag, bus_ready, mon_exp, $time);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic [1:0] mw, input logic [1:0] iw);
    step();
    cfg_we    = 1'b1;
    cfg_wdata = {iw, mw};
    step();
    cfg_we    = 1'b0;
  endtask

  // Driver: runs one bus cycle and queues the ready level of each clock
  task automatic bus_cycle(input logic m, input logic io, input logic rf,
                           input logic [1:0] sel, input logic [3:0] cw,
                           input int exp_n, input int ext_n, input string t);
    step();
    mem_req = m; io_req = io; refresh = rf; cs_sel = sel; cs_wait = cw;
    push(1'b1, t);
    for (int i = 0; i < exp_n; i++) begin
      step();
      push(1'b0, t);
    end
    for (int j = 0; j < ext_n; j++) begin
      if (j == 0) step(); else step();
      ext_wait = 1'b1;
      push(1'b0, t);
    end
    step();
    ext_wait = 1'b0;
    push(1'b1, t);
    step();
    mem_req = 1'b0; io_req = 1'b0; refresh = 1'b0; cs_sel = 2'b00; cs_wait = 4'h0;
    push(1'b1, t);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("[TB] FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 4'h0;
    mem_req = 1'b0; io_req = 1'b0; refresh = 1'b0;
    cs_sel = 2'b00; cs_wait = 4'h0; ext_wait = 1'b0;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1: reset state, ready high when idle
    @(negedge clk);
    n_tests++;
    if (bus_ready !== 1'b1) begin
      n_fail++;
      $display("[TB] FAIL R1: bus_ready=%b expected=1", bus_ready);
    end

    // R1 / R4: reset value 3 on memory cycles
    bus_cycle(1, 0, 0, 2'b00, 4'h0, 3, 0, "R1");
    // R1 / R5: reset value 3 on I/O cycles
    bus_cycle(0, 1, 0, 2'b00, 4'h0, 3, 0, "R1");

    // R2: program memory=1, I/O=2
    write_cfg(2'd1, 2'd2);
    bus_cycle(1, 0, 0, 2'b00, 4'h0, 1, 0, "R2");
    bus_cycle(0, 1, 0, 2'b00, 4'h0, 2, 0, "R5");
    // R5: both strobes at start -> memory count
    bus_cycle(1, 1, 0, 2'b00, 4'h0, 1, 0, "R5");

    // R6: merging by maximum
    bus_cycle(1, 0, 0, 2'b01, 4'b0011, 3, 0, "R6");
    bus_cycle(1, 0, 0, 2'b10, 4'b1000, 2, 0, "R6");
    bus_cycle(1, 0, 0, 2'b11, 4'b1110, 3, 0, "R6");
    bus_cycle(1, 0, 0, 2'b10, 4'b0011, 1, 0, "R6");
    bus_cycle(0, 1, 0, 2'b11, 4'b1111, 2, 0, "R6");

    // R7: refresh cycles get no waits
    bus_cycle(1, 0, 1, 2'b11, 4'b1111, 0, 0, "R7");

    // R8: external wait extends after programmed waits
    bus_cycle(1, 0, 0, 2'b00, 4'h0, 1, 2, "R8");

    // R4: zero programmed waits with I/O = 3
    write_cfg(2'd0, 2'd3);
    bus_cycle(1, 0, 0, 2'b00, 4'h0, 0, 0, "R4");
    bus_cycle(0, 1, 0, 2'b00, 4'h0, 3, 0, "R9");
    bus_cycle(0, 1, 0, 2'b00, 4'h0, 3, 1, "R8");

    // R3: strobe changes inside a cycle do not restart the wait
    write_cfg(2'd1, 2'd3);
    step();
    mem_req = 1'b1;
    push(1'b1, "R3");
    step(); push(1'b0, "R3");
    step(); push(1'b1, "R3");
    io_req = 1'b1;
    step(); push(1'b1, "R3");
    mem_req = 1'b0;
    step(); push(1'b1, "R3");
    step(); push(1'b1, "R3");
    io_req = 1'b0;
    step(); push(1'b1, "R3");

    repeat (4) step();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule